// File: doc/BRIEF.md
# DSP Fast Interrupt Sequencer

This block picks one pending interrupt for a small 24-bit DSP core and steers the program fetch stage through a fast service window. Sources in fixed priority order are reset, stack error, trace, software interrupt, two external lines and a host command. The host command carries its own vector address. The core tells the block each time an instruction completes (`boundary_i`), gives the program counter of the next sequential fetch (`pc_i`), and reports whether the instruction that just completed occupied two program words (`two_word_i`).

When a request is taken at a boundary, the block registers a one-cycle fetch override to the vector address and records the interrupted program counter. The phase counter is set to 3 and steps down once per boundary. If the first vector word was a single-word instruction, the word at vector+1 runs next. If the first word began a two-word instruction, no further word is taken from the slot. In both cases the block then issues a second override back to the saved program counter. Nothing is pushed to any stack. The acknowledge pulses tell the core which source was taken. For the host command, the acknowledge is also the DSP-side release of the host request.

Top module: `fastirq_seq`

## Requirements
- R1: The block accepts an interrupt only in a cycle where `boundary_i` is 1. In the next cycle, `ovr_valid_o` is 1 for exactly one cycle, and `ovr_addr_o` holds the slot address: reset 0x0000, stack error 0x0002, trace 0x0004, software 0x0006, line A 0x0008, line B 0x000A. At any other time `ovr_valid_o` is 0 outside the return override.
- R2: A `hcmd_pulse_i` pulse stores `hvec_i` with bit 0 cleared. A later host acceptance uses that stored value as the override address.
- R3: When several requests are eligible, one source is taken per boundary in this order: reset, stack error, trace, software, line A, line B, host. `ack_o` is one-hot in the acceptance cycle, with bit 0 = reset, 1 = stack error, 2 = trace, 3 = software, 4 = line A, 5 = line B, 6 = host.
- R4: While `mask_i` is 1, every source except reset is ignored at a boundary: there is no override, no acknowledge, and the phase is unchanged.
- R5: Reset is taken even when masked and even inside a service window. It overrides to 0x0000, sets `ack_o` bit 0, and forces the phase to 0 without saving the program counter.
- R6: A non-reset acceptance sets `phase_o` to 3 and records `pc_i`. If the next boundary reports a one-word instruction, the phase becomes 2 with no override. The boundary after that overrides to the saved PC and sets the phase to 1. The boundary after that sets the phase to 0.
- R7: If the boundary in phase 3 reports a two-word instruction, that same boundary overrides to the saved PC and sets the phase to 1. No override to vector+2 is ever issued.
- R8: While `phase_o` is not 0 at a boundary, no source other than reset is accepted.
- R9: Software and host pulses stay pending, including while masked, until they are accepted. Acceptance clears them, so a host command is taken once per pulse.
- R10: After reset, `ovr_valid_o`, `ack_o` and `phase_o` are 0. The phase changes only in a cycle that follows a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | An instruction completed this cycle |
| pc_i | input | 16 | Next sequential fetch address |
| two_word_i | input | 1 | The completed instruction was two words long |
| mask_i | input | 1 | Global mask for all sources except reset |
| req_reset_i | input | 1 | Reset request (level) |
| req_stkerr_i | input | 1 | Stack error request (level) |
| req_trace_i | input | 1 | Trace request (level) |
| req_irqa_i | input | 1 | External line A (level) |
| req_irqb_i | input | 1 | External line B (level) |
| swi_pulse_i | input | 1 | Software interrupt event (one-cycle pulse) |
| hcmd_pulse_i | input | 1 | Host command event (one-cycle pulse) |
| hvec_i | input | 16 | Host-supplied vector address |
| ovr_valid_o | output | 1 | Fetch override valid |
| ovr_addr_o | output | 16 | Fetch override address |
| ack_o | output | 7 | One-hot acknowledge of the accepted source |
| phase_o | output | 2 | Service phase counter |

## Verification
The assertions check on every cycle that the acknowledge is one-hot and that overrides follow only a boundary. They also check that the mask and an open window block every non-reset acceptance, that reset lands at 0x0000 with phase 0, that a non-reset acceptance always opens phase 3, and that the phase holds between boundaries. Other behaviours need the bench's scenarios, because they depend on values carried across several boundaries: the exact slot and host addresses, the saved PC used for the return, the early return after a two-word first instruction, the priority order, and software and host events that survive masking and are consumed exactly once.

// File: rtl/fastirq_pkg.sv
package fastirq_pkg;

    localparam int PADDR_W = 16;
    localparam int NSRC    = 7;

    // Source index doubles as priority rank (0 = highest).
    localparam int IDX_RST  = 0;
    localparam int IDX_STK  = 1;
    localparam int IDX_TRC  = 2;
    localparam int IDX_SWI  = 3;
    localparam int IDX_IRQA = 4;
    localparam int IDX_IRQB = 5;
    localparam int IDX_HOST = 6;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RET    = 2'd1,
        PH_SECOND = 2'd2,
        PH_FIRST  = 2'd3
    } phase_e;

    typedef struct packed {
        logic               valid;
        logic [PADDR_W-1:0] addr;
    } fetch_ovr_t;

    function automatic logic [PADDR_W-1:0] slot_of(input int idx, input int stride);
        slot_of = PADDR_W'(idx * stride);
    endfunction

endpackage

// File: rtl/fastirq_pend.sv
module fastirq_pend #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) pend_o[g] <= 1'b0;
            else     pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
        end
    end
endmodule

// File: rtl/fastirq_arb.sv
module fastirq_arb #(
    parameter int N = 7
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_rank
        assign grant_o[g]  = req_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | req_i[g];
    end
    assign any_o = seen[N];
endmodule

// File: rtl/fastirq_seq.sv
module fastirq_seq
    import fastirq_pkg::*;
#(
    parameter int SLOT_STRIDE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 boundary_i,
    input  logic [PADDR_W-1:0]   pc_i,
    input  logic                 two_word_i,
    input  logic                 mask_i,
    input  logic                 req_reset_i,
    input  logic                 req_stkerr_i,
    input  logic                 req_trace_i,
    input  logic                 req_irqa_i,
    input  logic                 req_irqb_i,
    input  logic                 swi_pulse_i,
    input  logic                 hcmd_pulse_i,
    input  logic [PADDR_W-1:0]   hvec_i,
    output logic                 ovr_valid_o,
    output logic [PADDR_W-1:0]   ovr_addr_o,
    output logic [NSRC-1:0]      ack_o,
    output logic [1:0]           phase_o
);
    localparam int NEDGE = 2;

    phase_e             phase_q;
    fetch_ovr_t         ovr_q, ovr_d;
    logic [NSRC-1:0]    ack_q;
    logic [PADDR_W-1:0] saved_pc_q;
    logic [PADDR_W-1:0] host_vec_q;

    // Edge-triggered sources: bit 0 software, bit 1 host.
    logic [NEDGE-1:0] edge_set, edge_clr, edge_pend;
    assign edge_set = {hcmd_pulse_i, swi_pulse_i};

    logic [NSRC-1:0] req, grant;
    logic            grant_any;

    fastirq_pend #(.N(NEDGE)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (edge_set),
        .clr_i  (edge_clr),
        .pend_o (edge_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)               host_vec_q <= '0;
        else if (hcmd_pulse_i) host_vec_q <= {hvec_i[PADDR_W-1:1], 1'b0};
    end

    logic open_win;
    assign open_win = boundary_i & ~mask_i & (phase_q == PH_IDLE);

    always_comb begin
        req           = '0;
        req[IDX_RST]  = boundary_i & req_reset_i;
        req[IDX_STK]  = open_win & req_stkerr_i;
        req[IDX_TRC]  = open_win & req_trace_i;
        req[IDX_SWI]  = open_win & edge_pend[0];
        req[IDX_IRQA] = open_win & req_irqa_i;
        req[IDX_IRQB] = open_win & req_irqb_i;
        req[IDX_HOST] = open_win & edge_pend[1];
    end

    fastirq_arb #(.N(NSRC)) u_arb (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (grant_any)
    );

    assign edge_clr = {grant[IDX_HOST], grant[IDX_SWI]};

    logic [PADDR_W-1:0] vec_addr;
    always_comb begin
        vec_addr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                if (i == IDX_HOST) vec_addr = host_vec_q;
                else               vec_addr = slot_of(i, SLOT_STRIDE);
            end
        end
    end

    phase_e phase_d;
    always_comb begin
        phase_d = phase_q;
        ovr_d   = '0;
        if (grant_any) begin
            ovr_d.valid = 1'b1;
            ovr_d.addr  = vec_addr;
            phase_d     = grant[IDX_RST] ? PH_IDLE : PH_FIRST;
        end else if (boundary_i) begin
            unique case (phase_q)
                PH_FIRST: begin
                    if (two_word_i) begin
                        ovr_d.valid = 1'b1;
                        ovr_d.addr  = saved_pc_q;
                        phase_d     = PH_RET;
                    end else begin
                        phase_d     = PH_SECOND;
                    end
                end
                PH_SECOND: begin
                    ovr_d.valid = 1'b1;
                    ovr_d.addr  = saved_pc_q;
                    phase_d     = PH_RET;
                end
                PH_RET:  phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            ovr_q      <= '0;
            ack_q      <= '0;
            saved_pc_q <= '0;
        end else begin
            phase_q <= phase_d;
            ovr_q   <= ovr_d;
            ack_q   <= grant;
            if (grant_any && !grant[IDX_RST]) saved_pc_q <= pc_i;
        end
    end

    assign ovr_valid_o = ovr_q.valid;
    assign ovr_addr_o  = ovr_q.addr;
    assign ack_o       = ack_q;
    assign phase_o     = phase_q;

endmodule

// File: rtl/fastirq_chk.sv
module fastirq_chk
    import fastirq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               boundary,
    input logic               mask,
    input logic               ovr_valid,
    input logic [PADDR_W-1:0] ovr_addr,
    input logic [NSRC-1:0]    ack,
    input logic [1:0]         phase
);
    assert_ovr_after_boundary_R1: assert property (@(posedge clk) disable iff (rst)
        ovr_valid |-> $past(boundary));

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));

    assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (boundary && mask) |=> (ack[NSRC-1:1] == '0));

    assert_reset_vector_R5: assert property (@(posedge clk) disable iff (rst)
        ack[0] |-> (ovr_valid && ovr_addr == '0 && phase == 2'd0));

    assert_accept_opens_window_R6: assert property (@(posedge clk) disable iff (rst)
        (ack[NSRC-1:1] != '0) |-> (phase == 2'd3 && ovr_valid));

    assert_no_nesting_R8: assert property (@(posedge clk) disable iff (rst)
        (boundary && phase != 2'd0) |=> (ack[NSRC-1:1] == '0));

    assert_phase_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(phase));
endmodule

bind fastirq_seq fastirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary_i),
    .mask      (mask_i),
    .ovr_valid (ovr_valid_o),
    .ovr_addr  (ovr_addr_o),
    .ack       (ack_o),
    .phase     (phase_o)
);

// File: tb/fastirq_seq_bench.sv
`timescale 1ns/1ps
module fastirq_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 0, two_word_i = 0, mask_i = 0;
    logic [15:0] pc_i = 16'h0;
    logic        req_reset_i = 0, req_stkerr_i = 0, req_trace_i = 0;
    logic        req_irqa_i = 0, req_irqb_i = 0, swi_pulse_i = 0, hcmd_pulse_i = 0;
    logic [15:0] hvec_i = 16'h0;
    logic        ovr_valid_o;
    logic [15:0] ovr_addr_o;
    logic [6:0]  ack_o;
    logic [1:0]  phase_o;

    always #10 clk = ~clk;

    fastirq_seq u_fastirq_seq (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .pc_i(pc_i),
        .two_word_i(two_word_i), .mask_i(mask_i), .req_reset_i(req_reset_i),
        .req_stkerr_i(req_stkerr_i), .req_trace_i(req_trace_i),
        .req_irqa_i(req_irqa_i), .req_irqb_i(req_irqb_i),
        .swi_pulse_i(swi_pulse_i), .hcmd_pulse_i(hcmd_pulse_i), .hvec_i(hvec_i),
        .ovr_valid_o(ovr_valid_o), .ovr_addr_o(ovr_addr_o),
        .ack_o(ack_o), .phase_o(phase_o)
    );

    typedef struct {
        bit          v;
        logic [15:0] addr;
        logic [6:0]  ack;
        logic [1:0]  ph;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   cmp_due = 0, done = 0;

    always @(posedge clk) cmp_due <= boundary_i & ~rst;

    // Monitor: compare one expected item per boundary, check quiet cycles otherwise.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cmp_due) begin
                exp_t e;
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard empty: v=%0b addr=%h ack=%b ph=%0d expected an item",
                             ovr_valid_o, ovr_addr_o, ack_o, phase_o);
                end else begin
                    e = q.pop_front();
                    if (ovr_valid_o !== e.v || (e.v && ovr_addr_o !== e.addr) ||
                        ack_o !== e.ack || phase_o !== e.ph) begin
                        n_fail++;
                        $display("FAIL %s: got v=%0b addr=%h ack=%b ph=%0d, expected v=%0b addr=%h ack=%b ph=%0d",
                                 e.tag, ovr_valid_o, ovr_addr_o, ack_o, phase_o,
                                 e.v, e.addr, e.ack, e.ph);
                    end
                end
            end else begin
                if (ovr_valid_o !== 1'b0 || ack_o !== 7'b0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R1 quiet cycle: got v=%0b ack=%b, expected v=0 ack=0",
                             ovr_valid_o, ack_o);
                end
            end
        end
    end

    task automatic step(input bit two, input bit v, input logic [15:0] addr,
                        input logic [6:0] ack, input logic [1:0] ph, input string tag);
        exp_t e;
        @(negedge clk);
        two_word_i = two;
        boundary_i = 1'b1;
        e.v = v; e.addr = addr; e.ack = ack; e.ph = ph; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1 boundary_i = 1'b0;
        two_word_i = 1'b0;
    endtask

    task automatic pulse_swi();
        @(negedge clk); swi_pulse_i = 1'b1;
        @(posedge clk); #1 swi_pulse_i = 1'b0;
    endtask

    task automatic pulse_host(input logic [15:0] v);
        @(negedge clk); hcmd_pulse_i = 1'b1; hvec_i = v;
        @(posedge clk); #1 hcmd_pulse_i = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (ovr_valid_o !== 0 || ack_o !== 0 || phase_o !== 0) begin
            n_fail++;
            $display("FAIL R10 reset state: got v=%0b ack=%b ph=%0d, expected 0 0 0",
                     ovr_valid_o, ack_o, phase_o);
        end

        // R1 R6: line A, one-word first instruction
        pc_i = 16'h0100; req_irqa_i = 1;
        step(0, 1, 16'h0008, 7'b0010000, 3, "R1 irqa slot");
        req_irqa_i = 0;
        step(0, 0, 16'h0, 7'b0, 2, "R6 second word no override");
        step(0, 1, 16'h0100, 7'b0, 1, "R6 return to saved pc");
        step(0, 0, 16'h0, 7'b0, 0, "R6 window closed");

        // R7: line B, two-word first instruction returns early
        pc_i = 16'h0200; req_irqb_i = 1;
        step(0, 1, 16'h000A, 7'b0100000, 3, "R1 irqb slot");
        req_irqb_i = 0; pc_i = 16'h0BAD;
        step(1, 1, 16'h0200, 7'b0, 1, "R7 early return");
        step(0, 0, 16'h0, 7'b0, 0, "R7 idle");

        // R3: trace beats line A and line B
        pc_i = 16'h0300; req_trace_i = 1; req_irqa_i = 1; req_irqb_i = 1;
        step(0, 1, 16'h0004, 7'b0000100, 3, "R3 trace first");
        req_trace_i = 0; req_irqa_i = 0; req_irqb_i = 0;
        step(1, 1, 16'h0300, 7'b0, 1, "R7 return");
        step(0, 0, 16'h0, 7'b0, 0, "R6 idle");

        // R4 R9: mask holds off level and edge sources, software stays pending
        pc_i = 16'h0400; mask_i = 1; req_irqa_i = 1;
        step(0, 0, 16'h0, 7'b0, 0, "R4 masked irqa ignored");
        pulse_swi();
        step(0, 0, 16'h0, 7'b0, 0, "R4 masked swi ignored");
        mask_i = 0; req_irqa_i = 0;
        step(0, 1, 16'h0006, 7'b0001000, 3, "R9 swi kept pending");
        step(1, 1, 16'h0400, 7'b0, 1, "R7 return after swi");
        step(0, 0, 16'h0, 7'b0, 0, "R6 idle");
        step(0, 0, 16'h0, 7'b0, 0, "R9 swi consumed once");

        // R2 R3 R9: software beats host; host vector bit 0 cleared; taken once
        pc_i = 16'h0500;
        pulse_host(16'h0027);
        pulse_swi();
        step(0, 1, 16'h0006, 7'b0001000, 3, "R3 swi beats host");
        step(1, 1, 16'h0500, 7'b0, 1, "R7 return");
        step(0, 0, 16'h0, 7'b0, 0, "R6 idle");
        step(0, 1, 16'h0026, 7'b1000000, 3, "R2 host vector");
        step(0, 0, 16'h0, 7'b0, 2, "R6 second word");
        step(0, 1, 16'h0500, 7'b0, 1, "R6 return after host");
        step(0, 0, 16'h0, 7'b0, 0, "R6 idle");
        step(0, 0, 16'h0, 7'b0, 0, "R9 host released once");

        // R8: no acceptance inside the window
        pc_i = 16'h0600; req_irqb_i = 1;
        step(0, 1, 16'h000A, 7'b0100000, 3, "R1 irqb");
        req_irqb_i = 0; req_irqa_i = 1;
        step(0, 0, 16'h0, 7'b0, 2, "R8 irqa blocked phase2");
        step(0, 1, 16'h0600, 7'b0, 1, "R8 irqa blocked at return");
        step(0, 0, 16'h0, 7'b0, 0, "R8 irqa blocked phase1");
        step(0, 1, 16'h0008, 7'b0010000, 3, "R8 irqa after window");
        req_irqa_i = 0;

        // R5: reset aborts the window
        req_reset_i = 1;
        step(0, 1, 16'h0000, 7'b0000001, 0, "R5 reset in window");
        req_reset_i = 0;
        step(0, 0, 16'h0, 7'b0, 0, "R5 no window after reset");

        // R3: stack error beats line A
        pc_i = 16'h0700; req_stkerr_i = 1; req_irqa_i = 1;
        step(0, 1, 16'h0002, 7'b0000010, 3, "R3 stack error first");
        req_stkerr_i = 0; req_irqa_i = 0;
        step(1, 1, 16'h0700, 7'b0, 1, "R7 return");
        step(0, 0, 16'h0, 7'b0, 0, "R6 idle");

        // R5: reset ignores the mask
        mask_i = 1; req_reset_i = 1; req_irqa_i = 1;
        step(0, 1, 16'h0000, 7'b0000001, 0, "R5 reset while masked");
        req_reset_i = 0; req_irqa_i = 0; mask_i = 0;

        repeat (3) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard leftover: got %0d items, expected 0", q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule